// File: doc/BRIEF.md
# Hierarchical Interrupt Aggregator

The aggregator collects up to 256 interrupt lines and folds them into one host interrupt through three summary levels. Lines are grouped eight to a block, and blocks eight to a master. A root byte says which masters hold pending work. Software walks the tree from root to master to block to line. Each line has its own trigger setting: edge or level, and a separate mask for each polarity. Every line latches its events into a pending bit, which software clears explicitly.

All access goes through a byte-wide register port in a nine-byte window. Per-line state is reached indirectly. Software first writes a block number into a select register. A status read then returns that block's eight pending bits. A configuration write carries a 3-bit index that picks one line of the selected block. The serial transport that would carry these accesses lies outside the block.

Top module: `irq_agg`

## Requirements
- R1: The window starts at 0x1BB and has these offsets: +0 root, +1..+4 master status 0..3, +5 block select, +6 block status, +7 configuration, +8 live input levels. Line n lives in block n/8 at bit n%8. Block b belongs to master b/8 at bit b%8. Block select reads back the last value written to it.
- R2: Edge mode (cfg bit0 = 0). A 0-to-1 change on a line sets its pending bit when cfg bit2 is 0. A 1-to-0 change sets it when cfg bit1 is 0. Both edges may be armed at once.
- R3: Level mode (cfg bit0 = 1). The line pends while it is high if bit2 is 0, and while it is low if bit1 is 0. With both bits at 1 the line never pends.
- R4: A configuration byte takes effect only when its bit7 is 1. Bits 6:4 then choose the line within the selected block. When bit7 is 0 the whole write, including the clear, is ignored.
- R5: Bit3 of an accepted configuration write clears the chosen pending bit at that clock edge. A level line that is still active and unmasked pends again one cycle later.
- R6: Master status m, bit i, is 1 when block m*8+i has any pending bit. Root bit m+1 is 1 when master m has any block pending. Root bit 0 always reads 0.
- R7: `irq_o` is a register holding the OR of all master indications. It falls one cycle after the last pending bit is cleared.
- R8: Writes to root, master status, block status and live levels are ignored. Reads of the configuration byte and of any address outside the window return 0.
- R9: Reset clears every pending bit and sets both mask bits on every line, so no line can pend before it is configured.
- R10: The live-levels register returns the synchronized input levels of the selected block, bit k for line k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 256 | Interrupt lines, asynchronous to clk_i |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 10 | Register address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data, combinational from addr_i |
| irq_o | output | 1 | Summary interrupt to the host |

## Verification
Directed cases drive one line at a time under each trigger setting: rising only, both edges, active-high level and active-low level. These separate edge latching from level re-arming, and show that a masked polarity has no effect. A clear issued on a still-active level line tells a same-cycle clear apart from a lost or delayed re-set. Random phases give all 256 lines random settings and random full-width input vectors, with scattered clears. Each block, master and root byte is then compared with a bench model, which exposes decoding, numbering and tree mistakes that single-line cases cannot reach.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned BLK_BITS = 8;

  localparam logic [3:0] OFS_ROOT  = 4'd0;
  localparam logic [3:0] OFS_MST   = 4'd1;
  localparam logic [3:0] OFS_BSEL  = 4'd5;
  localparam logic [3:0] OFS_BSTAT = 4'd6;
  localparam logic [3:0] OFS_CFG   = 4'd7;
  localparam logic [3:0] OFS_LIVE  = 4'd8;

  typedef struct packed {
    logic mask_re;  // cfg bit2
    logic mask_fe;  // cfg bit1
    logic lvl;      // cfg bit0
  } cfg_t;

  localparam cfg_t CFG_RST = '{mask_re: 1'b1, mask_fe: 1'b1, lvl: 1'b0};
endpackage

// File: rtl/irq_agg_cell.sv
module irq_agg_cell
  import irq_agg_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic irq_i,
  input  logic cfg_we_i,
  input  cfg_t cfg_i,
  input  logic clr_i,
  output logic pend_o,
  output logic live_o
);
  logic s1_q, s2_q, prev_q, pend_q, set_c;
  cfg_t cfg_q;

  always_comb begin
    if (cfg_q.lvl)
      set_c = (s2_q & ~cfg_q.mask_re) | (~s2_q & ~cfg_q.mask_fe);
    else
      set_c = (s2_q & ~prev_q & ~cfg_q.mask_re) | (~s2_q & prev_q & ~cfg_q.mask_fe);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
      pend_q <= 1'b0;
      cfg_q  <= CFG_RST;
    end else begin
      s1_q   <= irq_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
      if (cfg_we_i) cfg_q <= cfg_i;
      if (clr_i)      pend_q <= 1'b0;  // clear beats a same-cycle set
      else if (set_c) pend_q <= 1'b1;
    end
  end

  assign pend_o = pend_q;
  assign live_o = s2_q;

  a_r5_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !pend_q);
  a_r3_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_q) |-> $past(!(cfg_q.mask_re && cfg_q.mask_fe)));
  a_r2_edge_needs_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(pend_q) && $past(!cfg_q.lvl)) |-> $past(s2_q != prev_q));
endmodule

// File: rtl/irq_agg_tree.sv
module irq_agg_tree
  import irq_agg_pkg::*;
#(
  parameter int unsigned N_IN = 256
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic [N_IN-1:0]                     pend_i,
  output logic [N_IN/BLK_BITS-1:0]            blk_any_o,
  output logic [(N_IN/BLK_BITS+BLK_BITS-1)/BLK_BITS-1:0] mst_any_o,
  output logic                                irq_o
);
  localparam int unsigned N_BLK = N_IN / BLK_BITS;
  localparam int unsigned N_MST = (N_BLK + BLK_BITS - 1) / BLK_BITS;
  localparam int unsigned PAD_W = N_MST * BLK_BITS;

  logic [PAD_W-1:0] blk_pad;
  logic irq_q;

  for (genvar b = 0; b < N_BLK; b++) begin : g_blk
    assign blk_any_o[b] = |pend_i[b*BLK_BITS +: BLK_BITS];
  end

  assign blk_pad = PAD_W'(blk_any_o);

  for (genvar m = 0; m < N_MST; m++) begin : g_mst
    assign mst_any_o[m] = |blk_pad[m*BLK_BITS +: BLK_BITS];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |mst_any_o;
  end

  assign irq_o = irq_q;

  a_r7_irq_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_q) |-> $past(mst_any_o == '0));
  a_r7_irq_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_q) |-> $past(pend_i != '0));
endmodule

// File: rtl/irq_agg.sv
module irq_agg
  import irq_agg_pkg::*;
#(
  parameter int unsigned N_IN = 256,
  parameter logic [9:0]  BASE = 10'h1BB
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_IN-1:0] irq_i,
  input  logic            we_i,
  input  logic [9:0]      addr_i,
  input  logic [7:0]      wdata_i,
  output logic [7:0]      rdata_o,
  output logic            irq_o
);
  localparam int unsigned N_BLK = N_IN / BLK_BITS;
  localparam int unsigned N_MST = (N_BLK + BLK_BITS - 1) / BLK_BITS;
  localparam int unsigned SEL_W = $clog2(N_BLK);
  localparam int unsigned PAD_W = N_MST * BLK_BITS;

  logic [9:0]       ofs;
  logic [3:0]       ofs4;
  logic             hit, cfg_wr;
  logic [SEL_W-1:0] sel_q;
  cfg_t             cfg_new;
  logic [N_IN-1:0]  pend, live, line_we;
  logic [N_BLK-1:0] blk_any;
  logic [N_MST-1:0] mst_any;
  logic [PAD_W-1:0] blk_pad;
  logic [7:0]       root_b;

  assign ofs    = addr_i - BASE;
  assign ofs4   = ofs[3:0];
  assign hit    = (addr_i >= BASE) && (ofs <= 10'd8);
  assign cfg_wr = we_i && hit && (ofs4 == OFS_CFG) && wdata_i[7];
  assign cfg_new = '{mask_re: wdata_i[2], mask_fe: wdata_i[1], lvl: wdata_i[0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= '0;
    else if (we_i && hit && ofs4 == OFS_BSEL) sel_q <= wdata_i[SEL_W-1:0];
  end

  for (genvar i = 0; i < N_IN; i++) begin : g_line
    assign line_we[i] = cfg_wr && (sel_q == SEL_W'(i / BLK_BITS))
                        && (wdata_i[6:4] == 3'(i % BLK_BITS));
    irq_agg_cell u_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .irq_i    (irq_i[i]),
      .cfg_we_i (line_we[i]),
      .cfg_i    (cfg_new),
      .clr_i    (line_we[i] && wdata_i[3]),
      .pend_o   (pend[i]),
      .live_o   (live[i])
    );
  end

  irq_agg_tree #(.N_IN(N_IN)) u_tree (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pend_i    (pend),
    .blk_any_o (blk_any),
    .mst_any_o (mst_any),
    .irq_o     (irq_o)
  );

  assign blk_pad = PAD_W'(blk_any);
  assign root_b  = 8'({mst_any, 1'b0});  // bit0 is not a master

  always_comb begin
    rdata_o = '0;
    if (hit) begin
      case (ofs4)
        OFS_ROOT:  rdata_o = root_b;
        OFS_BSEL:  rdata_o = 8'(sel_q);
        OFS_BSTAT: rdata_o = pend[int'(sel_q)*BLK_BITS +: BLK_BITS];
        OFS_LIVE:  rdata_o = live[int'(sel_q)*BLK_BITS +: BLK_BITS];
        default: begin
          if (ofs4 >= OFS_MST && ofs4 < OFS_MST + 4'(N_MST))
            rdata_o = blk_pad[(int'(ofs4) - int'(OFS_MST))*BLK_BITS +: BLK_BITS];
        end
      endcase
    end
  end

  a_r8_outside_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i < BASE || addr_i > BASE + 10'd8) |-> (rdata_o == 8'h00));
  a_r6_root_bit0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == BASE) |-> !rdata_o[0]);
  a_r1_sel_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == BASE + 10'd5) |=> $stable(sel_q));
endmodule

// File: tb/irq_agg_tb.sv
module irq_agg_tb;
  localparam int N = 256;
  localparam logic [9:0] A_ROOT = 10'h1BB;
  localparam logic [9:0] A_MST  = 10'h1BC;
  localparam logic [9:0] A_BSEL = 10'h1C0;
  localparam logic [9:0] A_BST  = 10'h1C1;
  localparam logic [9:0] A_CFG  = 10'h1C2;
  localparam logic [9:0] A_LIVE = 10'h1C3;

  logic clk_i = 1'b0, rst_ni = 1'b0, we = 1'b0;
  logic [N-1:0] irq = '0;
  logic [9:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic irq_o;

  int n_chk = 0, n_err = 0;
  logic [2:0] m_cfg [N];
  bit m_pend [N];
  logic [N-1:0] v_cur = '0;

  always #10 clk_i = ~clk_i;

  irq_agg u_dut (.clk_i(clk_i), .rst_ni(rst_ni), .irq_i(irq), .we_i(we),
                 .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq_o));

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [9:0] a, logic [7:0] d);
    @(negedge clk_i); we = 1'b1; addr = a; wdata = d;
    @(negedge clk_i); we = 1'b0;
  endtask

  task automatic rd(logic [9:0] a, output logic [7:0] d);
    @(negedge clk_i); addr = a; #1; d = rdata;
  endtask

  task automatic cfg_wr(int n, logic [2:0] c, bit clr);
    wr(A_BSEL, 8'(n / 8));
    wr(A_CFG, {1'b1, 3'(n % 8), clr, c});
    m_cfg[n] = c;
    if (clr) m_pend[n] = 1'b0;
  endtask

  function automatic bit lvl_act(int n, bit v);
    logic [2:0] c = m_cfg[n];
    return c[0] && ((v && !c[2]) || (!v && !c[1]));
  endfunction

  task automatic settle();
    repeat (3) @(negedge clk_i);
    for (int n = 0; n < N; n++) if (lvl_act(n, v_cur[n])) m_pend[n] = 1'b1;
  endtask

  task automatic drive(logic [N-1:0] nv);
    @(negedge clk_i); irq = nv;
    for (int n = 0; n < N; n++) begin
      logic [2:0] c = m_cfg[n];
      if (!c[0] && ((nv[n] && !v_cur[n] && !c[2]) || (!nv[n] && v_cur[n] && !c[1])))
        m_pend[n] = 1'b1;
    end
    v_cur = nv;
    repeat (5) @(negedge clk_i);
    settle();
  endtask

  function automatic logic [7:0] exp_blk(int b);
    logic [7:0] e;
    for (int k = 0; k < 8; k++) e[k] = m_pend[b*8+k];
    return e;
  endfunction

  task automatic check_blk(int b, string tag);
    logic [7:0] d;
    wr(A_BSEL, 8'(b));
    rd(A_BST, d);
    chk(tag, d, exp_blk(b));
  endtask

  task automatic check_all(string tag);
    logic [7:0] d, e, root;
    root = '0;
    for (int b = 0; b < 32; b++) check_blk(b, {tag, " R1 block status"});
    for (int m = 0; m < 4; m++) begin
      e = '0;
      for (int i = 0; i < 8; i++) e[i] = |exp_blk(m*8+i);
      rd(A_MST + 10'(m), d);
      chk({tag, " R6 master status"}, d, e);
      root[m+1] = |e;
    end
    rd(A_ROOT, d);
    chk({tag, " R6 root"}, d, root);
    chk({tag, " R7 irq_o"}, irq_o, int'(|root));
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_err++; n_chk++;
    $display("FAIL watchdog: got hang expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd5417));
    for (int n = 0; n < N; n++) begin m_cfg[n] = 3'b110; m_pend[n] = 1'b0; end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R9 reset state
    rd(A_ROOT, d); chk("R9 root after reset", d, 0);
    chk("R9 irq_o after reset", irq_o, 0);
    rd(A_BSEL, d); chk("R9 block select after reset", d, 0);
    drive('1);
    check_all("R9 all high, masked");
    drive('0);
    check_all("R9 all low, masked");

    // R4 write without bit7 ignored (line 13 = block 1 bit 5)
    wr(A_BSEL, 8'd1);
    wr(A_CFG, {1'b0, 3'd5, 1'b0, 3'b010});
    drive(N'(1) << 13);
    check_blk(1, "R4 bit7 clear ignored");
    drive('0);

    // R2 rising only
    cfg_wr(13, 3'b010, 1'b1); settle();
    drive(N'(1) << 13);
    wr(A_BSEL, 8'd1); rd(A_BST, d); chk("R2 rising sets", d, 8'h20);
    rd(A_MST, d); chk("R6 master0 block1", d, 8'h02);
    rd(A_ROOT, d); chk("R6 root master0", d, 8'h02);
    chk("R7 irq_o set", irq_o, 1);
    @(negedge clk_i); we = 1'b1; addr = A_CFG; wdata = {1'b1, 3'd5, 1'b1, 3'b010};
    @(negedge clk_i); we = 1'b0; addr = A_BST; #1;
    chk("R5 clear same cycle", rdata, 0);
    chk("R7 irq_o held one cycle", irq_o, 1);
    @(negedge clk_i); #1;
    chk("R7 irq_o drops after clear", irq_o, 0);
    m_pend[13] = 1'b0;
    drive('0);
    wr(A_BSEL, 8'd1); rd(A_BST, d); chk("R2 falling masked", d, 0);

    // R2 both edges
    cfg_wr(13, 3'b000, 1'b1); settle();
    drive(N'(1) << 13);
    check_blk(1, "R2 both edges rise");
    cfg_wr(13, 3'b000, 1'b1); settle();
    drive('0);
    wr(A_BSEL, 8'd1); rd(A_BST, d); chk("R2 both edges fall", d, 8'h20);
    cfg_wr(13, 3'b000, 1'b1); settle();

    // R3 level active-high (line 20 = block 2 bit 4)
    cfg_wr(20, 3'b011, 1'b1); settle();
    wr(A_BSEL, 8'd2); rd(A_BST, d); chk("R3 active-high idle low", d, 0);
    drive(N'(1) << 20);
    wr(A_BSEL, 8'd2); rd(A_BST, d); chk("R3 active-high pends", d, 8'h10);
    @(negedge clk_i); we = 1'b1; addr = A_CFG; wdata = {1'b1, 3'd4, 1'b1, 3'b011};
    @(negedge clk_i); we = 1'b0; addr = A_BST; #1;
    chk("R5 level clear same cycle", rdata, 0);
    @(negedge clk_i); #1;
    chk("R5 level re-sets next cycle", rdata, 8'h10);
    drive('0);
    check_blk(2, "R3 latched after release");
    cfg_wr(20, 3'b011, 1'b1); settle();
    check_blk(2, "R3 cleared when inactive");
    cfg_wr(20, 3'b101, 1'b1); settle();
    wr(A_BSEL, 8'd2); rd(A_BST, d); chk("R3 active-low pends", d, 8'h10);
    cfg_wr(20, 3'b111, 1'b1); settle();
    repeat (4) @(negedge clk_i);
    wr(A_BSEL, 8'd2); rd(A_BST, d); chk("R3 both masks disable", d, 0);

    // R10 live levels
    drive(N'(1) << 20 | N'(1) << 23);
    wr(A_BSEL, 8'd2); rd(A_LIVE, d); chk("R10 live levels", d, 8'h90);
    drive('0);
    wr(A_BSEL, 8'd2); rd(A_LIVE, d); chk("R10 live levels low", d, 0);

    // R8 read-only, config and outside reads
    cfg_wr(40, 3'b011, 1'b1); settle();
    drive(N'(1) << 40);
    wr(A_ROOT, 8'hFF); wr(A_MST, 8'hFF); wr(A_BST, 8'hFF); wr(A_LIVE, 8'hFF);
    check_all("R8 after read-only writes");
    rd(A_CFG, d); chk("R8 config reads zero", d, 0);
    rd(A_ROOT - 10'd1, d); chk("R8 below window", d, 0);
    rd(A_LIVE + 10'd1, d); chk("R8 above window", d, 0);
    rd(10'h000, d); chk("R8 address zero", d, 0);
    wr(A_BSEL, 8'd17); rd(A_BSEL, d); chk("R1 select readback", d, 17);

    // random phase
    for (int n = 0; n < N; n++) cfg_wr(n, 3'($urandom), 1'b1);
    settle();
    check_all("R2 R3 random config");
    for (int s = 0; s < 24; s++) begin
      drive({$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom});
      if (s % 3 == 2) begin
        for (int j = 0; j < 8; j++) begin
          int n = int'($urandom % N);
          cfg_wr(n, m_cfg[n], 1'b1);
        end
        settle();
      end
      check_all("R2 R3 R5 random step");
    end
    finish_run();
  end
endmodule